// File: doc/BRIEF.md
# Quad DAC serial command decoder

This block is the write-only serial front end of a four-channel, 16-bit DAC register bank. An external host opens a frame by pulling the active-low frame select low, then clocks 32 bits in on the line `sdi`, most significant bit first. Each bit is taken on a falling edge of the serial clock. The serial lines are sampled by the block's own system clock, so the serial clock must run well below that clock. When the 32nd bit arrives, the frame is decoded at once, even if frame select is still low.

Each channel has two registers: a holding register and an output register. The output registers drive the `dac_q` port. Frame bits 27:24 carry the opcode and bits 23:20 carry the channel address. Bits 19:4 carry the data word, and bits 3:0 carry per-channel flags. Bits 31:28 are don't-care. The opcodes can do the following:
- load a holding register,
- move a holding register to its output,
- load one channel and refresh every output,
- load and output in one step,
- set the power-down modes, the clear code, the load-mask or the reference control bits,
- restore the whole bank to zero.

Top module: `qdac_cmd_decoder`

## Requirements
- R1: While reset is asserted and after its release, every output register, power-down mode, clear code, load mask, chain bit and reference bit reads zero.
- R2: Opcode 0000 loads data bits 19:4 into the holding register of the addressed channel and leaves every output unchanged. Address 0000 to 0011 selects channel 0 to 3.
- R3: Opcode 0001 copies the holding register of the addressed channel into its output register. No other channel changes.
- R4: Opcode 0010 loads the addressed holding register. It then copies all four holding registers into their output registers.
- R5: Opcode 0011 loads data bits 19:4 into both the holding and the output register of the addressed channel.
- R6: Address 1111 applies opcodes 0000 to 0011 to all four channels at once.
- R7: Opcode 0100 writes the 2-bit mode in frame bits 9:8 into the power-down field of every channel whose mask bit is set (frame bit n for channel n). Other channels keep their mode. The address is ignored.
- R8: Opcode 0101 loads the clear code from frame bits 1:0. Opcode 0110 loads the load mask from bits 3:0. Opcode 1000 loads the chain-enable bit from bit 1 and the reference-on bit from bit 0.
- R9: Opcode 0111 clears all holding, output and control registers to zero, whatever the address.
- R10: Opcodes 1001 to 1111 change nothing. Opcodes 0000 to 0011 with address 0100 to 1110 change nothing.
- R11: If frame select rises before the 32nd falling serial clock edge, the partial frame is dropped and nothing changes.
- R12: After a frame completes, further serial clock edges while frame select stays low are ignored. A new frame needs a fresh falling edge of frame select.
- R13: The frame takes effect within a few system clocks of the 32nd falling serial clock edge, while frame select is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data, MSB first |
| dac_q | output | 64 | Output registers; channel n at bits 16n+15:16n |
| pd_q | output | 8 | Power-down modes; channel n at bits 2n+1:2n |
| clr_q | output | 2 | Clear code |
| ldac_q | output | 4 | Load mask, one bit per channel |
| dcen_q | output | 1 | Chain-enable bit |
| ref_q | output | 1 | Reference-on bit |

## Verification
The assertions assume the following about the serial lines:
- They change slowly enough that every serial clock level is held for several system clocks after the synchronizer.
- Frame select never falls in the same sample as a serial clock falling edge.

Under these conditions, a completed frame is a single-cycle pulse, and registers move only in the cycle after it. The stimulus keeps within these limits in two ways. It holds each serial clock phase for four system clocks, and it moves frame select only while the serial clock is low and idle. The checks then cover every channel address, every data-path opcode, every power-down mode and mask, the unused codes, truncated frames and surplus clock edges.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int FRM_BITS  = 32;
  localparam int PAY_W     = 28;
  localparam int DAT_W     = 16;
  localparam int OP_HI     = 27;
  localparam int OP_LO     = 24;
  localparam int AD_HI     = 23;
  localparam int AD_LO     = 20;
  localparam int DT_HI     = 19;
  localparam int DT_LO     = 4;
  localparam int PM_HI     = 9;
  localparam int PM_LO     = 8;

  localparam logic [3:0] OP_WR_HOLD  = 4'h0;
  localparam logic [3:0] OP_XFER     = 4'h1;
  localparam logic [3:0] OP_WR_BCAST = 4'h2;
  localparam logic [3:0] OP_WR_OUT   = 4'h3;
  localparam logic [3:0] OP_PWR      = 4'h4;
  localparam logic [3:0] OP_CLRCODE  = 4'h5;
  localparam logic [3:0] OP_LDMASK   = 4'h6;
  localparam logic [3:0] OP_RESET    = 4'h7;
  localparam logic [3:0] OP_REFCTL   = 4'h8;
  localparam logic [3:0] ADDR_ALL    = 4'hF;
endpackage

// File: rtl/qdac_serial_rx.sv
module qdac_serial_rx
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsel_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             frm_vld,
  output logic [PAY_W-1:0] frm_word
);
  localparam int CNT_W = $clog2(FRM_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRM_BITS - 1);

  logic [SYNC_STAGES-1:0] fsel_sr, sclk_sr, sdi_sr;
  logic                   fsel_d, sclk_d;
  logic                   fsel_s, sclk_s, sdi_s;
  logic                   fsel_fall, sclk_fall;
  logic                   armed_q, armed_n;
  logic [CNT_W-1:0]       cnt_q, cnt_n;
  logic [PAY_W-1:0]       shf_q, shf_n;
  logic                   vld_q, vld_n;

  assign fsel_s    = fsel_sr[SYNC_STAGES-1];
  assign sclk_s    = sclk_sr[SYNC_STAGES-1];
  assign sdi_s     = sdi_sr[SYNC_STAGES-1];
  assign fsel_fall = fsel_d & ~fsel_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_sr <= '1;
      sclk_sr <= '0;
      sdi_sr  <= '0;
      fsel_d  <= 1'b1;
      sclk_d  <= 1'b0;
    end else begin
      fsel_sr <= {fsel_sr[SYNC_STAGES-2:0], fsel_n};
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
      sdi_sr  <= {sdi_sr[SYNC_STAGES-2:0], sdi};
      fsel_d  <= fsel_s;
      sclk_d  <= sclk_s;
    end
  end

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    shf_n   = shf_q;
    vld_n   = 1'b0;
    if (fsel_s) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end else if (fsel_fall) begin
      armed_n = 1'b1;
      cnt_n   = '0;
    end else if (armed_q && sclk_fall) begin
      shf_n = {shf_q[PAY_W-2:0], sdi_s};
      if (cnt_q == LAST_BIT) begin
        vld_n   = 1'b1;
        armed_n = 1'b0;
        cnt_n   = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shf_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      shf_q   <= shf_n;
      vld_q   <= vld_n;
    end
  end

  assign frm_vld  = vld_q;
  assign frm_word = shf_q;
endmodule

// File: rtl/qdac_cmd_exec.sv
module qdac_cmd_exec
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_vld,
  input  logic [PAY_W-1:0]        frm_word,
  output logic [NUM_CH*DAT_W-1:0] dac_q,
  output logic [2*NUM_CH-1:0]     pd_q,
  output logic [1:0]              clr_q,
  output logic [NUM_CH-1:0]       ldac_q,
  output logic                    dcen_q,
  output logic                    ref_q
);
  logic [3:0]       op, addr;
  logic [DAT_W-1:0] data;
  logic [1:0]       pmode;
  logic [3:0]       flags;
  logic             addr_all, addr_ok, wr_hold, upd_all, rst_cmd;
  logic [1:0]       clr_n;
  logic [NUM_CH-1:0] ldac_n;
  logic             dcen_n, ref_n;

  assign op       = frm_word[OP_HI:OP_LO];
  assign addr     = frm_word[AD_HI:AD_LO];
  assign data     = frm_word[DT_HI:DT_LO];
  assign pmode    = frm_word[PM_HI:PM_LO];
  assign flags    = frm_word[3:0];
  assign addr_all = (addr == ADDR_ALL);
  assign addr_ok  = addr_all || (32'(addr) < NUM_CH);
  assign wr_hold  = frm_vld && addr_ok &&
                    (op == OP_WR_HOLD || op == OP_WR_BCAST || op == OP_WR_OUT);
  assign upd_all  = frm_vld && addr_ok && (op == OP_WR_BCAST);
  assign rst_cmd  = frm_vld && (op == OP_RESET);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic             hit;
    logic [DAT_W-1:0] hold_q, hold_n, out_q, out_n;
    logic [1:0]       pdm_q, pdm_n;

    assign hit = addr_ok && (addr_all || (32'(addr) == ch));

    always_comb begin
      hold_n = hold_q;
      out_n  = out_q;
      pdm_n  = pdm_q;
      if (rst_cmd) begin
        hold_n = '0;
        out_n  = '0;
        pdm_n  = '0;
      end else if (frm_vld) begin
        if (wr_hold && hit) hold_n = data;
        if (upd_all) out_n = hold_n;
        else if (hit && op == OP_XFER) out_n = hold_q;
        else if (hit && op == OP_WR_OUT) out_n = data;
        if (op == OP_PWR && flags[ch]) pdm_n = pmode;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        out_q  <= '0;
        pdm_q  <= '0;
      end else begin
        hold_q <= hold_n;
        out_q  <= out_n;
        pdm_q  <= pdm_n;
      end
    end

    assign dac_q[ch*DAT_W +: DAT_W] = out_q;
    assign pd_q[2*ch +: 2]          = pdm_q;
  end

  always_comb begin
    clr_n  = clr_q;
    ldac_n = ldac_q;
    dcen_n = dcen_q;
    ref_n  = ref_q;
    if (rst_cmd) begin
      clr_n  = '0;
      ldac_n = '0;
      dcen_n = 1'b0;
      ref_n  = 1'b0;
    end else if (frm_vld) begin
      if (op == OP_CLRCODE) clr_n = flags[1:0];
      if (op == OP_LDMASK)  ldac_n = flags[NUM_CH-1:0];
      if (op == OP_REFCTL) begin
        dcen_n = flags[1];
        ref_n  = flags[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= '0;
      ldac_q <= '0;
      dcen_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      clr_q  <= clr_n;
      ldac_q <= ldac_n;
      dcen_q <= dcen_n;
      ref_q  <= ref_n;
    end
  end
endmodule

// File: rtl/qdac_cmd_decoder.sv
module qdac_cmd_decoder
  import qdac_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fsel_n,
  input  logic                    sclk,
  input  logic                    sdi,
  output logic [NUM_CH*DAT_W-1:0] dac_q,
  output logic [2*NUM_CH-1:0]     pd_q,
  output logic [1:0]              clr_q,
  output logic [NUM_CH-1:0]       ldac_q,
  output logic                    dcen_q,
  output logic                    ref_q
);
  logic [1:0]       rst_sr;
  logic             rst_ls;
  logic             frm_vld;
  logic [PAY_W-1:0] frm_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_ls = rst_sr[1];

  qdac_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_ls),
    .fsel_n   (fsel_n),
    .sclk     (sclk),
    .sdi      (sdi),
    .frm_vld  (frm_vld),
    .frm_word (frm_word)
  );

  qdac_cmd_exec #(.NUM_CH(NUM_CH)) u_exec (
    .clk      (clk),
    .rst_n    (rst_ls),
    .frm_vld  (frm_vld),
    .frm_word (frm_word),
    .dac_q    (dac_q),
    .pd_q     (pd_q),
    .clr_q    (clr_q),
    .ldac_q   (ldac_q),
    .dcen_q   (dcen_q),
    .ref_q    (ref_q)
  );
endmodule

// File: rtl/qdac_cmd_decoder_chk.sv
module qdac_cmd_decoder_chk
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_ls,
  input logic                    frm_vld,
  input logic [PAY_W-1:0]        frm_word,
  input logic [NUM_CH*DAT_W-1:0] dac_q,
  input logic [2*NUM_CH-1:0]     pd_q,
  input logic [1:0]              clr_q,
  input logic [NUM_CH-1:0]       ldac_q,
  input logic                    dcen_q,
  input logic                    ref_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (dac_q == '0 && pd_q == '0 && clr_q == '0 && ldac_q == '0 && !dcen_q && !ref_q));

  // R11
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    !frm_vld |=> $stable(dac_q));

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    !frm_vld |=> $stable({pd_q, clr_q, ldac_q, dcen_q, ref_q}));

  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    frm_vld |=> !frm_vld);

  // R9
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    (frm_vld && frm_word[OP_HI:OP_LO] == OP_RESET) |=>
      (dac_q == '0 && pd_q == '0 && clr_q == '0 && ldac_q == '0 && !dcen_q && !ref_q));

  // R6
  write_all_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    (frm_vld && frm_word[OP_HI:OP_LO] == OP_WR_OUT && frm_word[AD_HI:AD_LO] == ADDR_ALL) |=>
      (dac_q == {NUM_CH{$past(frm_word[DT_HI:DT_LO])}}));

  // R5
  write_ch0_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    (frm_vld && frm_word[OP_HI:OP_LO] == OP_WR_OUT && frm_word[AD_HI:AD_LO] == 4'h0) |=>
      (dac_q[DAT_W-1:0] == $past(frm_word[DT_HI:DT_LO])));
endmodule

bind qdac_cmd_decoder qdac_cmd_decoder_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_ls   (rst_ls),
  .frm_vld  (frm_vld),
  .frm_word (frm_word),
  .dac_q    (dac_q),
  .pd_q     (pd_q),
  .clr_q    (clr_q),
  .ldac_q   (ldac_q),
  .dcen_q   (dcen_q),
  .ref_q    (ref_q)
);

// File: tb/qdac_cmd_decoder_bench.sv
module qdac_cmd_decoder_bench;
  logic        clk;
  logic        rst_n;
  logic        fsel_n;
  logic        sclk;
  logic        sdi;
  logic [63:0] dac_q;
  logic [7:0]  pd_q;
  logic [1:0]  clr_q;
  logic [3:0]  ldac_q;
  logic        dcen_q;
  logic        ref_q;

  int n_chk;
  int n_fail;
  bit done;

  logic [15:0] hold_m [4];
  logic [15:0] out_m  [4];
  logic [1:0]  pd_m   [4];
  logic [1:0]  clr_m;
  logic [3:0]  ldac_m;
  logic        dcen_m;
  logic        ref_m;

  qdac_cmd_decoder u_qdac_cmd_decoder (
    .clk    (clk),
    .rst_n  (rst_n),
    .fsel_n (fsel_n),
    .sclk   (sclk),
    .sdi    (sdi),
    .dac_q  (dac_q),
    .pd_q   (pd_q),
    .clr_q  (clr_q),
    .ldac_q (ldac_q),
    .dcen_q (dcen_q),
    .ref_q  (ref_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] ad,
                                     input logic [15:0] dt, input logic [3:0] lo);
    return {4'hA, op, ad, dt, lo};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      hold_m[i] = '0; out_m[i] = '0; pd_m[i] = '0;
    end
    clr_m = '0; ldac_m = '0; dcen_m = 1'b0; ref_m = 1'b0;
  endtask

  task automatic model_apply(input logic [31:0] w);
    logic [3:0] op, ad;
    logic [15:0] dt;
    bit ok;
    op = w[27:24]; ad = w[23:20]; dt = w[19:4];
    ok = (ad < 4) || (ad == 4'hF);
    case (op)
      4'h0, 4'h2, 4'h3: if (ok) begin
        for (int i = 0; i < 4; i++)
          if (ad == 4'hF || ad == 4'(i)) begin
            hold_m[i] = dt;
            if (op == 4'h3) out_m[i] = dt;
          end
        if (op == 4'h2)
          for (int i = 0; i < 4; i++) out_m[i] = hold_m[i];
      end
      4'h1: if (ok)
        for (int i = 0; i < 4; i++)
          if (ad == 4'hF || ad == 4'(i)) out_m[i] = hold_m[i];
      4'h4: for (int i = 0; i < 4; i++) if (w[i]) pd_m[i] = w[9:8];
      4'h5: clr_m = w[1:0];
      4'h6: ldac_m = w[3:0];
      4'h7: model_clear();
      4'h8: begin dcen_m = w[1]; ref_m = w[0]; end
      default: ;
    endcase
  endtask

  task automatic check_all(input string tag);
    logic [63:0] e_dac;
    logic [7:0]  e_pd;
    e_dac = {out_m[3], out_m[2], out_m[1], out_m[0]};
    e_pd  = {pd_m[3], pd_m[2], pd_m[1], pd_m[0]};
    n_chk++;
    if (dac_q !== e_dac || pd_q !== e_pd || clr_q !== clr_m || ldac_q !== ldac_m ||
        dcen_q !== dcen_m || ref_q !== ref_m) begin
      n_fail++;
      $display("FAIL %s: dac=%h pd=%h clr=%h ldac=%h dcen=%b ref=%b expected dac=%h pd=%h clr=%h ldac=%h dcen=%b ref=%b",
               tag, dac_q, pd_q, clr_q, ldac_q, dcen_q, ref_q,
               e_dac, e_pd, clr_m, ldac_m, dcen_m, ref_m);
    end
  endtask

  task automatic open_frame();
    fsel_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_frame();
    fsel_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdi  = w[31-i];
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    open_frame();
    shift_bits(w, 32);
    close_frame();
    repeat (8) @(negedge clk);
    model_apply(w);
    check_all(tag);
  endtask

  initial begin
    int lim;
    lim = 150000;
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] adl [5];
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; fsel_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check_all("R1 reset held");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release");

    // R2 R3 R4 R5 R6: data-path opcodes over every valid address
    adl = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hF};
    for (int a = 0; a < 5; a++) begin
      for (int op = 0; op < 4; op++) begin
        logic [15:0] dt;
        string tag;
        dt = 16'((a + 1) * 16'h1F3B + op * 16'h0A51 + 16'h0123);
        case (op)
          0: tag = "R2 hold write";
          1: tag = "R3 transfer";
          2: tag = "R4 write and refresh all";
          default: tag = "R5 write through";
        endcase
        if (adl[a] == 4'hF) tag = {"R6 ", tag};
        send(mk(4'(op), adl[a], dt, 4'h0), tag);
      end
      send(mk(4'h0, adl[a], 16'hC0DE ^ 16'(a), 4'h0), "R2 hold only");
    end

    // R7: every mode with every mask
    for (int md = 0; md < 4; md++)
      for (int mk4 = 0; mk4 < 16; mk4++) begin
        logic [31:0] w;
        w = mk(4'h4, 4'(mk4 ^ 4'h5), 16'h0, 4'(mk4));
        w[9:8] = 2'(md);
        send(w, "R7 power-down");
      end

    // R8: control registers
    for (int v = 0; v < 4; v++) send(mk(4'h5, 4'h2, 16'hFFFF, 4'(v) | 4'hC), "R8 clear code");
    for (int v = 0; v < 16; v++) send(mk(4'h6, 4'h1, 16'h5555, 4'(v)), "R8 load mask");
    for (int v = 0; v < 4; v++) send(mk(4'h8, 4'h0, 16'hAAAA, 4'(v)), "R8 reference");

    // R10: unused opcodes and addresses
    for (int op = 9; op < 16; op++) send(mk(4'(op), 4'h0, 16'hFFFF, 4'hF), "R10 reserved opcode");
    for (int ad = 4; ad < 15; ad++)
      for (int op = 0; op < 4; op++)
        send(mk(4'(op), 4'(ad), 16'h9ABC + 16'(ad), 4'h0), "R10 unlisted address");

    // R11: truncated frames are dropped
    foreach (adl[k]) begin
      int nb;
      nb = (k == 0) ? 1 : (k == 1) ? 16 : (k == 2) ? 28 : 31;
      if (k < 4) begin
        open_frame();
        shift_bits(mk(4'h3, 4'hF, 16'hDEAD, 4'hF), nb);
        close_frame();
        repeat (8) @(negedge clk);
        check_all("R11 partial frame");
      end
    end

    // R13: executes with frame select still low; R12: extra edges ignored
    open_frame();
    shift_bits(mk(4'h3, 4'h1, 16'h7E57, 4'h0), 32);
    repeat (8) @(negedge clk);
    model_apply(mk(4'h3, 4'h1, 16'h7E57, 4'h0));
    check_all("R13 update before frame select rises");
    shift_bits(mk(4'h3, 4'hF, 16'h0BAD, 4'h0), 32);
    repeat (8) @(negedge clk);
    check_all("R12 surplus edges ignored");
    close_frame();
    send(mk(4'h3, 4'h2, 16'h4242, 4'h0), "R12 new frame after fresh select");

    // R9: reset opcode
    send(mk(4'h6, 4'h0, 16'h0, 4'hF), "R8 load mask before reset");
    send(mk(4'h7, 4'h9, 16'h1234, 4'hF), "R9 reset opcode");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule